// File: doc/BRIEF.md
# Reference Clock Loss Monitor

This block decides whether an external reference clock is still running fast enough. It counts rising edges of the reference over a fixed window of slow internal timebase cycles. If a window holds fewer edges than a minimum, the reference is declared lost. The minimum is taken from one of two parameters. A range select input chooses which one applies.

When a loss is declared, the block always sends a one-cycle pulse to clear an external PLL lock indication. It then does one of two things, depending on a policy input. It either raises a system reset request, or it sets a sticky status flag that drives an interrupt line. Software clears the flag with a write-one strobe.

While monitoring is enabled, the block asks for the slow timebase to be kept running. It also reports an error if a low-power entry request arrives while monitoring is still on. Monitoring must be switched off before such a mode is entered. The first window after the enable rises is thrown away, because it may have started part-way through.

Top module: `refclk_loss_monitor`

## Requirements
- R1: `slow_clk_req` equals `mon_en` at all times, so the measuring timebase is held on whenever monitoring is enabled.
- R2: With monitoring enabled and the reference stopped, a loss event (`pll_lock_clr` high for one cycle) occurs, and it repeats once per measuring window.
- R3: The minimum edge count per window is MIN_HI (4) when `range_hi`=1 and MIN_LO (2) when `range_hi`=0. A reference with a 1000 ns period gives 2 or 3 edges per window, so it counts as lost only with `range_hi`=1.
- R4: A reference with at least the minimum number of edges in every window never produces a loss event.
- R5: On a loss event with `reset_on_loss`=1, `sys_rst_req` rises in the same cycle as `pll_lock_clr` and stays high until `rst_n` is asserted. `loss_flag` is not set by that event.
- R6: On a loss event with `reset_on_loss`=0, `loss_flag` rises in the same cycle as `pll_lock_clr`. The flag is sticky. `loss_irq` always equals `loss_flag`.
- R7: `pll_lock_clr` is a single-cycle pulse per loss event, in either policy. Every pulse comes together with a set `loss_flag` or `sys_rst_req`.
- R8: `loss_clr` held high for one clock clears `loss_flag` on that edge. If a loss event sets the flag at the same edge, the set wins.
- R9: `lp_err` is high in the cycle after an edge that saw `lp_req` and `mon_en` both high, and low otherwise.
- R10: The first window after `mon_en` rises is discarded, so no loss event appears within one window of enabling.
- R11: While `mon_en` is low, no loss event is produced.
- R12: After reset, `loss_flag`, `loss_irq`, `sys_rst_req`, `pll_lock_clr` and `lp_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; status, policy and flag logic run on it |
| rst_n | input | 1 | Synchronous active-low reset, system domain |
| slow_clk | input | 1 | Slow internal timebase used as the measuring clock |
| ref_clk | input | 1 | Monitored external reference clock |
| mon_en | input | 1 | Monitor enable (system domain) |
| range_hi | input | 1 | 1 selects the high minimum, 0 the low minimum |
| reset_on_loss | input | 1 | 1 requests a reset on loss, 0 sets flag and interrupt |
| loss_clr | input | 1 | Write-one-to-clear strobe for the loss flag |
| lp_req | input | 1 | Request to enter a stop or very-low-power mode |
| slow_clk_req | output | 1 | Keeps the slow timebase running |
| loss_flag | output | 1 | Sticky loss status |
| loss_irq | output | 1 | Interrupt request, level, follows the flag |
| sys_rst_req | output | 1 | System reset request, sticky until reset |
| pll_lock_clr | output | 1 | One-cycle pulse clearing the PLL lock status |
| lp_err | output | 1 | Low-power entry attempted with monitor enabled |

## Verification
The system-domain outputs are exact to the cycle. `lp_err` follows its inputs by one clock. `loss_flag` and `sys_rst_req` move at the same edge as the `pll_lock_clr` pulse. A clear acts at the edge that samples the strobe. The bench reference model therefore predicts these outputs at every falling edge from the inputs applied at the previous rising edge.

A loss event is only due within a window, because of the slow-domain measurement and the two synchronisers. With a 32-cycle window of an 80 ns timebase (128 system cycles), a stopped reference must give its first event no sooner than 200 system cycles after enabling (R10) and no later than 450. Healthy and disabled cases must stay silent for at least 500 system cycles. Once a first event has been seen, events repeat every 128 system cycles exactly. The bench uses this to place a clear strobe on the very edge of the next set and check R8.

// File: rtl/clkmon_pkg.sv
// Shared types and helpers for the reference clock loss monitor.
package clkmon_pkg;

    // Action taken on a loss event.
    typedef enum logic {
        LOSS_ACT_FLAG  = 1'b0,
        LOSS_ACT_RESET = 1'b1
    } loss_act_e;

    // Returns the minimum edge count for the selected range.
    function automatic int unsigned pick_min(input logic hi,
                                             input int unsigned min_hi,
                                             input int unsigned min_lo);
        return hi ? min_hi : min_lo;
    endfunction

endpackage

// File: rtl/clkmon_sync.sv
// Multi-stage level synchroniser.
// Assumes: d changes no faster than the destination clock can sample.
// The reset is synchronous and active-low in the destination domain.
module clkmon_sync #(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned WIDTH   = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/clkmon_meter.sv
// Slow-domain frequency meter.
// Samples the reference, counts its rising edges over WIN slow cycles, and
// toggles loss_tgl at the end of every armed window whose count is below the
// selected minimum. The first window after enable only arms the meter.
// Assumes: slow_clk runs at least 2.5 times faster than the monitored
// reference, so every reference level is seen by the sampler.
module clkmon_meter #(
    parameter int unsigned WIN    = 32,
    parameter int unsigned MIN_HI = 4,
    parameter int unsigned MIN_LO = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic slow_clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic mon_en,
    input  logic range_hi,
    output logic loss_tgl
);

    localparam int unsigned WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int unsigned CNT_W = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] THR_HI = CNT_W'(MIN_HI);
    localparam logic [CNT_W-1:0] THR_LO = CNT_W'(MIN_LO);

    logic             rst_s_n;
    logic [2:0]       syn_q;
    logic             en_s, range_s, ref_s, ref_d, rise;
    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] edge_cnt, edge_tot, thr;
    logic             armed, win_end;

    // Bring the system reset into the slow domain.
    clkmon_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
        .clk(slow_clk), .rst_n(1'b1), .d(rst_n), .q(rst_s_n)
    );

    // Bring enable, range and the reference level into the slow domain.
    clkmon_sync #(.STAGES(STAGES), .WIDTH(3), .RST_VAL(1'b0)) u_in_sync (
        .clk(slow_clk), .rst_n(rst_s_n), .d({mon_en, range_hi, ref_clk}), .q(syn_q)
    );

    assign {en_s, range_s, ref_s} = syn_q;
    assign rise     = ref_s & ~ref_d;
    assign win_end  = (win_cnt == WIN_W'(WIN - 1));
    assign edge_tot = edge_cnt + {{(CNT_W-1){1'b0}}, rise};
    assign thr      = CNT_W'(clkmon_pkg::pick_min(range_s, THR_HI, THR_LO));

    // Count windows and edges, arm after the first window, toggle on loss.
    always_ff @(posedge slow_clk) begin
        if (!rst_s_n) begin
            ref_d    <= 1'b0;
            win_cnt  <= '0;
            edge_cnt <= '0;
            armed    <= 1'b0;
            loss_tgl <= 1'b0;
        end else begin
            ref_d <= ref_s;
            if (!en_s) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                armed    <= 1'b0;
            end else if (win_end) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                armed    <= 1'b1;
                if (armed && (edge_tot < thr)) loss_tgl <= ~loss_tgl;
            end else begin
                win_cnt  <= win_cnt + 1'b1;
                edge_cnt <= edge_tot;
            end
        end
    end

    // R10: a loss toggle only ever follows an armed window.
    a_r10_armed_before_loss: assert property (@(posedge slow_clk) disable iff (!rst_s_n)
        (loss_tgl != $past(loss_tgl)) |-> $past(armed));

    // R2: an armed window with no edges at all always toggles.
    a_r2_silent_window_loses: assert property (@(posedge slow_clk) disable iff (!rst_s_n)
        (en_s && win_end && armed && edge_tot == '0) |=> (loss_tgl != $past(loss_tgl)));

    // R11: a disabled meter keeps its count and arming cleared.
    a_r11_idle_when_off: assert property (@(posedge slow_clk) disable iff (!rst_s_n)
        !en_s |=> (edge_cnt == '0 && !armed));

endmodule

// File: rtl/clkmon_ctrl.sv
// System-domain loss handling.
// Turns each change of the meter's loss toggle into one event. Each event
// produces a PLL lock clear pulse plus either a reset request or the sticky
// flag. Also checks low-power entry against the enable.
// Assumes: mon_en, reset_on_loss, loss_clr and lp_req are synchronous to
// sys_clk, and loss toggles are at least a few system cycles apart.
module clkmon_ctrl #(
    parameter int unsigned STAGES = 2
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic loss_tgl,
    input  logic mon_en,
    input  logic reset_on_loss,
    input  logic loss_clr,
    input  logic lp_req,
    output logic loss_flag,
    output logic loss_irq,
    output logic sys_rst_req,
    output logic pll_lock_clr,
    output logic lp_err
);

    import clkmon_pkg::*;

    logic      tgl_s, tgl_d, evt;
    loss_act_e act;

    // Synchronise the loss toggle into the system domain.
    clkmon_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_tgl_sync (
        .clk(sys_clk), .rst_n(rst_n), .d(loss_tgl), .q(tgl_s)
    );

    assign evt = (tgl_s ^ tgl_d) & mon_en;
    assign act = reset_on_loss ? LOSS_ACT_RESET : LOSS_ACT_FLAG;

    // Register the event outcome, the sticky status and the low-power check.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            tgl_d        <= 1'b0;
            pll_lock_clr <= 1'b0;
            loss_flag    <= 1'b0;
            sys_rst_req  <= 1'b0;
            lp_err       <= 1'b0;
        end else begin
            tgl_d        <= tgl_s;
            pll_lock_clr <= evt;
            loss_flag    <= (loss_flag & ~loss_clr) | (evt & (act == LOSS_ACT_FLAG));
            sys_rst_req  <= sys_rst_req | (evt & (act == LOSS_ACT_RESET));
            lp_err       <= lp_req & mon_en;
        end
    end

    assign loss_irq = loss_flag;

    // R7: each clear pulse lasts one cycle.
    a_r7_single_pulse: assert property (@(posedge sys_clk) disable iff (!rst_n)
        pll_lock_clr |=> !pll_lock_clr);

    // R7: each clear pulse comes with a recorded outcome.
    a_r7_pulse_has_outcome: assert property (@(posedge sys_clk) disable iff (!rst_n)
        pll_lock_clr |-> (loss_flag || sys_rst_req));

    // R5: a reset request holds until reset.
    a_r5_reset_sticky: assert property (@(posedge sys_clk) disable iff (!rst_n)
        sys_rst_req |=> sys_rst_req);

    // R8: a clear with no competing event empties the flag.
    a_r8_clear_works: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (loss_clr && !evt) |=> !loss_flag);

    // R9: low-power entry while enabled raises the error.
    a_r9_lp_error: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (lp_req && mon_en) |=> lp_err);

    // R11: no event is passed on while disabled.
    a_r11_no_event_off: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !mon_en |=> !pll_lock_clr);

endmodule

// File: rtl/refclk_loss_monitor.sv
// Top level of the reference clock loss monitor.
// Joins the slow-domain meter to the system-domain loss handling and keeps
// the slow timebase requested while monitoring is on.
// Assumes: slow_clk is running whenever slow_clk_req is high.
module refclk_loss_monitor #(
    parameter int unsigned WIN_CYCLES  = 32,
    parameter int unsigned MIN_HI      = 4,
    parameter int unsigned MIN_LO      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic slow_clk,
    input  logic ref_clk,
    input  logic mon_en,
    input  logic range_hi,
    input  logic reset_on_loss,
    input  logic loss_clr,
    input  logic lp_req,
    output logic slow_clk_req,
    output logic loss_flag,
    output logic loss_irq,
    output logic sys_rst_req,
    output logic pll_lock_clr,
    output logic lp_err
);

    logic loss_tgl;

    // R1: the timebase request follows the enable directly.
    assign slow_clk_req = mon_en;

    // Measure the reference in the slow domain.
    clkmon_meter #(
        .WIN(WIN_CYCLES), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO), .STAGES(SYNC_STAGES)
    ) u_meter (
        .slow_clk(slow_clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .mon_en(mon_en), .range_hi(range_hi), .loss_tgl(loss_tgl)
    );

    // Handle loss events in the system domain.
    clkmon_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
        .sys_clk(sys_clk), .rst_n(rst_n), .loss_tgl(loss_tgl),
        .mon_en(mon_en), .reset_on_loss(reset_on_loss), .loss_clr(loss_clr),
        .lp_req(lp_req), .loss_flag(loss_flag), .loss_irq(loss_irq),
        .sys_rst_req(sys_rst_req), .pll_lock_clr(pll_lock_clr), .lp_err(lp_err)
    );

endmodule

// File: tb/tb_refclk_loss_monitor.sv
`timescale 1ns/1ps
module tb_refclk_loss_monitor;

    logic sys_clk = 1'b0, slow_clk = 1'b0, ref_clk = 1'b0;
    logic rst_n = 1'b0, mon_en = 1'b0, range_hi = 1'b0, reset_on_loss = 1'b0;
    logic loss_clr = 1'b0, lp_req = 1'b0;
    logic slow_clk_req, loss_flag, loss_irq, sys_rst_req, pll_lock_clr, lp_err;

    int  checks = 0, fails = 0, evt_cnt = 0;
    int  ref_half = 200;
    bit  ref_run = 1'b1, go = 1'b0, done = 1'b0;
    bit  a_rstn, a_en, a_rol, a_clr, a_lp, prev_pll;
    bit  m_flag, m_rst, m_lp;

    refclk_loss_monitor dut (
        .sys_clk(sys_clk), .rst_n(rst_n), .slow_clk(slow_clk), .ref_clk(ref_clk),
        .mon_en(mon_en), .range_hi(range_hi), .reset_on_loss(reset_on_loss),
        .loss_clr(loss_clr), .lp_req(lp_req), .slow_clk_req(slow_clk_req),
        .loss_flag(loss_flag), .loss_irq(loss_irq), .sys_rst_req(sys_rst_req),
        .pll_lock_clr(pll_lock_clr), .lp_err(lp_err)
    );

    always #10 sys_clk = ~sys_clk;
    always #40 slow_clk = ~slow_clk;
    always begin
        if (ref_run) #(ref_half) ref_clk = ~ref_clk;
        else #20;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Record the inputs seen by the design at each rising edge.
    always @(posedge sys_clk) begin
        a_rstn = rst_n; a_en = mon_en; a_rol = reset_on_loss;
        a_clr = loss_clr; a_lp = lp_req; go = 1'b1;
    end

    // Reference model, stepped and compared on every clock.
    always @(negedge sys_clk) begin
        if (go) begin
            if (!a_rstn) begin
                m_flag = 0; m_rst = 0; m_lp = 0;
                chk(pll_lock_clr == 0, "R12 pll clear in reset", pll_lock_clr, 0);
            end else begin
                if (pll_lock_clr) evt_cnt++;
                chk(!(pll_lock_clr && prev_pll), "R7 pulse width", 2, 1);
                chk(!pll_lock_clr || a_en, "R11 event while disabled", pll_lock_clr, 0);
                m_flag = (m_flag & ~a_clr) | (pll_lock_clr & ~a_rol);
                m_rst  = m_rst | (pll_lock_clr & a_rol);
                m_lp   = a_lp & a_en;
            end
            prev_pll = pll_lock_clr;
            chk(loss_flag == m_flag, "R6/R8 loss_flag", loss_flag, m_flag);
            chk(loss_irq == m_flag, "R6 loss_irq", loss_irq, m_flag);
            chk(sys_rst_req == m_rst, "R5 sys_rst_req", sys_rst_req, m_rst);
            chk(lp_err == m_lp, "R9 lp_err", lp_err, m_lp);
            chk(slow_clk_req == mon_en, "R1 slow_clk_req", slow_clk_req, mon_en);
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(negedge sys_clk); #1; end
    endtask

    task automatic wait_evt(input int max, output bit got);
        got = 0;
        for (int i = 0; i < max && !got; i++) begin
            cyc(1);
            if (pll_lock_clr) got = 1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        bit got;
        cyc(20);
        chk(loss_flag == 0 && loss_irq == 0 && sys_rst_req == 0 && lp_err == 0,
            "R12 reset state", loss_flag | sys_rst_req | lp_err, 0);
        rst_n = 1'b1;
        cyc(10);

        // R1 and R4: healthy 400 ns reference, low then high range.
        mon_en = 1'b1;
        chk(slow_clk_req == 1, "R1 request on enable", slow_clk_req, 1);
        base = evt_cnt; cyc(600);
        chk(evt_cnt == base, "R4 healthy low range", evt_cnt - base, 0);
        mon_en = 1'b0; cyc(20); range_hi = 1'b1; mon_en = 1'b1;
        base = evt_cnt; cyc(600);
        chk(evt_cnt == base, "R4 healthy high range", evt_cnt - base, 0);

        // R9: low-power request while enabled, then while disabled.
        lp_req = 1'b1; cyc(1); lp_req = 1'b0;
        chk(lp_err == 1, "R9 error while enabled", lp_err, 1);
        mon_en = 1'b0; cyc(5); lp_req = 1'b1; cyc(1); lp_req = 1'b0;
        chk(lp_err == 0, "R9 no error while disabled", lp_err, 0);

        // R10 and R2: stopped reference, first window ignored.
        ref_run = 1'b0; cyc(20);
        mon_en = 1'b1; base = evt_cnt; cyc(200);
        chk(evt_cnt == base, "R10 first window ignored", evt_cnt - base, 0);
        wait_evt(250, got);
        chk(got, "R2 loss on stopped reference", got, 1);
        chk(loss_flag == 1 && loss_irq == 1, "R6 flag and irq set", loss_flag, 1);

        // R8: clear strobe on the same edge as the next set; set must win.
        cyc(127); loss_clr = 1'b1; cyc(1); loss_clr = 1'b0;
        chk(pll_lock_clr == 1, "R2 periodic event", pll_lock_clr, 1);
        chk(loss_flag == 1, "R8 set wins over clear", loss_flag, 1);

        // R11: disabled monitor stays silent.
        mon_en = 1'b0; cyc(10);
        loss_clr = 1'b1; cyc(1); loss_clr = 1'b0;
        chk(loss_flag == 0, "R8 clear takes effect", loss_flag, 0);
        base = evt_cnt; cyc(500);
        chk(evt_cnt == base, "R11 no events when off", evt_cnt - base, 0);

        // R3: 1000 ns reference passes low range, fails high range.
        ref_half = 500; ref_run = 1'b1; range_hi = 1'b0; cyc(20);
        mon_en = 1'b1; base = evt_cnt; cyc(700);
        chk(evt_cnt == base, "R3 low range accepts", evt_cnt - base, 0);
        mon_en = 1'b0; cyc(20); range_hi = 1'b1; cyc(5); mon_en = 1'b1;
        wait_evt(450, got);
        chk(got, "R3 high range rejects", got, 1);
        mon_en = 1'b0; cyc(10);
        loss_clr = 1'b1; cyc(1); loss_clr = 1'b0;

        // R5: reset policy on a stopped reference.
        ref_run = 1'b0; reset_on_loss = 1'b1; cyc(20);
        mon_en = 1'b1;
        wait_evt(450, got);
        chk(got, "R5 loss seen", got, 1);
        chk(sys_rst_req == 1 && loss_flag == 0, "R5 reset not flag", sys_rst_req, 1);
        cyc(200);
        chk(sys_rst_req == 1, "R5 request held", sys_rst_req, 1);

        // R12: reset clears the request.
        mon_en = 1'b0; rst_n = 1'b0; cyc(10);
        chk(sys_rst_req == 0 && loss_flag == 0, "R12 reset clears", sys_rst_req, 0);
        finish_run();
    end

endmodule